// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block turns a captured start address into the stream of word addresses that a NOR-style array needs for a synchronous burst read. A 16-bit configuration word sets the read mode, the first-access latency, the polarity of the wait indication, the wrap behaviour and the burst length. The configuration word is written with a one-cycle strobe. In synchronous mode the start address is captured on a clock edge where chip enable and the address-valid strobe are both low. After the programmed latency the block presents one word address per clock. While the first word is not yet ready it drives the wait output to its asserted level.

When the mode bit selects asynchronous page mode, no clocked sequencing takes place. The output address follows the input address directly, so the upper bits pick the page and the two lowest bits pick one of four words in it. Data is flagged valid whenever chip enable is low, and the wait output stays deasserted. The sequencer has no storage array and no analog pin timing.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, the configuration selects asynchronous page mode, wait active-high, no wrapping, continuous length and latency code 3. In this state `wait_pin` is 0, `lat_rsvd` is 0 and `word_addr` follows `addr_in`.
- R2: In asynchronous page mode (config bit 15 = 1), `word_addr` equals `addr_in` in the same cycle, with `addr_in[1:0]` choosing the word in the page. `data_valid` equals `!ce_n`, `wait_pin` stays at its deasserted level and `adv_n` has no effect.
- R3: In synchronous mode (bit 15 = 0), a clock edge with `ce_n`=0 and `adv_n`=0 captures `addr_in`. With effective latency L (config bits 14:11), `data_valid` first rises in the cycle after the L-th edge following the capture edge, and `word_addr` then equals the captured address.
- R4: In synchronous mode, `wait_pin` is asserted from the capture until the first valid word and is deasserted while `data_valid` is high or no burst is running.
- R5: Config bit 10 sets the wait polarity: 1 means asserted is high, 0 means asserted is low.
- R6: With config bit 3 = 1 (no wrap), a finite burst emits N consecutive incrementing addresses across any alignment boundary, one per clock. `data_valid` then falls.
- R7: With bit 3 = 0 (wrap), a finite burst emits N addresses that increment inside the N-aligned window of the start address, wrapping to the window base, and then ends.
- R8: In continuous mode the address increments by one each clock with no bound. A clock edge with `ce_n`=1 ends any burst, so `data_valid` is 0 afterwards.
- R9: Latency codes 0 and 1 act as code 2 and raise `lat_rsvd`; codes 2 to 15 keep `lat_rsvd` at 0.
- R10: A capture that arrives on the same edge as the final beat of a running burst wins: the new burst's latency period starts at once and the old burst does not continue.
- R11: Length field bits 2:0 encode 001 = 4 words, 010 = 8 words and 011 = 16 words. Every other value, including 111, means continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads `cfg_word` into the configuration register |
| cfg_word | input | 16 | Configuration value |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | AW | Start or page address |
| word_addr | output | AW | Current word address |
| data_valid | output | 1 | Word address is valid for data |
| wait_pin | output | 1 | Wait indication, polarity from config bit 10 |
| lat_rsvd | output | 1 | Configured latency code is a reserved one |

## Verification
Two things can land on the same clock edge: the final beat of a finite burst, which would close the burst, and a fresh address capture, which opens a new one. The bench provokes this by lowering `adv_n` with a new address during the cycle that shows the last word of a 4-word burst. It then expects, in the next cycle, no valid data, an asserted wait and afterwards the new sequence. A design that let the end-of-burst win would drop the new burst, and the bench would see no data. A second collision is `ce_n` rising during a continuous burst, which must override the address advance. The bench judges it by `data_valid` and `wait_pin` going quiet one edge later.

// File: rtl/bas_pkg.sv
package bas_pkg;

   localparam int CFG_W  = 16;
   localparam int LAT_W  = 4;
   localparam int BEAT_W = 4;

   // size class of a burst: 0 = 4 words, 1 = 8, 2 = 16, 3 = continuous
   typedef logic [1:0] size_cls_t;
   localparam size_cls_t SZ_CONT = 2'd3;

   typedef struct packed {
      logic             async_md;  // bit 15
      logic [LAT_W-1:0] lat;       // bits 14:11
      logic             wait_hi;   // bit 10
      logic             no_wrap;   // bit 3
      logic [2:0]       len;       // bits 2:0
   } cfg_t;

   function automatic cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
      cfg_t c;
      c.async_md = w[15];
      c.lat      = w[14:11];
      c.wait_hi  = w[10];
      c.no_wrap  = w[3];
      c.len      = w[2:0];
      return c;
   endfunction

   function automatic size_cls_t len_class(input logic [2:0] code);
      case (code)
         3'b001:  return 2'd0;
         3'b010:  return 2'd1;
         3'b011:  return 2'd2;
         default: return SZ_CONT;
      endcase
   endfunction

   function automatic logic [BEAT_W-1:0] last_beat(input size_cls_t s);
      case (s)
         2'd0:    return BEAT_W'(3);
         2'd1:    return BEAT_W'(7);
         default: return BEAT_W'(15);
      endcase
   endfunction

endpackage

// File: rtl/bas_cfg_reg.sv
module bas_cfg_reg
   import bas_pkg::*;
#(
   parameter int DEF_LAT = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CFG_W-1:0] word,
   output cfg_t             cfg,
   output logic [LAT_W-1:0] lat_eff,
   output logic             lat_rsvd
);

   localparam logic [LAT_W-1:0] MIN_LAT = LAT_W'(2);
   localparam logic [CFG_W-1:0] RST_WORD =
      {1'b1, LAT_W'(DEF_LAT), 1'b1, 6'b0, 1'b1, 3'b111};

   generate
      if (DEF_LAT < 2 || DEF_LAT >= (1 << LAT_W)) begin : g_bad_lat
         $error("DEF_LAT must be a legal latency code");
      end
   endgenerate

   logic [CFG_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  word_q <= RST_WORD;
      else if (wr) word_q <= word;
   end

   assign cfg      = unpack_cfg(word_q);
   assign lat_rsvd = (cfg.lat < MIN_LAT);
   assign lat_eff  = lat_rsvd ? MIN_LAT : cfg.lat;

endmodule

// File: rtl/bas_lat_timer.sv
module bas_lat_timer #(
   parameter int CW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] lat,
   output logic          ready
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= lat;
      else if (cnt != '0)  cnt <= cnt - CW'(1);
   end

   assign ready = (cnt == '0);

endmodule

// File: rtl/bas_addr_gen.sv
module bas_addr_gen
   import bas_pkg::*;
#(
   parameter int AW = 24
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] start,
   input  logic          step,
   input  size_cls_t     size_cls,
   input  logic          wrap_en,
   output logic [AW-1:0] addr_q
);

   localparam int NWIN = 3;

   generate
      if (AW < 6) begin : g_bad_aw
         $error("AW must cover the 16-word window plus page bits");
      end
   endgenerate

   logic [AW-1:0] cand [NWIN];
   logic [AW-1:0] nxt;

   generate
      for (genvar k = 0; k < NWIN; k++) begin : g_win
         localparam int WB = 2 + k;
         assign cand[k] = {addr_q[AW-1:WB], addr_q[WB-1:0] + WB'(1)};
      end
   endgenerate

   always_comb begin
      if (wrap_en && size_cls != SZ_CONT) nxt = cand[size_cls];
      else                                nxt = addr_q + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     addr_q <= '0;
      else if (load)  addr_q <= start;
      else if (step)  addr_q <= nxt;
   end

   AST_NOWRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && (!wrap_en || size_cls == SZ_CONT)) |=> addr_q == $past(addr_q) + AW'(1)); // R6

   AST_WRAP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && wrap_en && size_cls != SZ_CONT) |=> addr_q[AW-1:4] == $past(addr_q[AW-1:4])); // R7

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bas_pkg::*;
#(
   parameter int AW      = 24,
   parameter int DEF_LAT = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             ce_n,
   input  logic             adv_n,
   input  logic [AW-1:0]    addr_in,
   output logic [AW-1:0]    word_addr,
   output logic             data_valid,
   output logic             wait_pin,
   output logic             lat_rsvd
);

   cfg_t              cfg;
   logic [LAT_W-1:0]  lat_eff;
   logic              sync_md, cap, ready, valid, last, step;
   logic              active, wrap_q;
   size_cls_t         len_q;
   logic [BEAT_W-1:0] beat;
   logic [AW-1:0]     addr_q;

   bas_cfg_reg #(.DEF_LAT(DEF_LAT)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .word(cfg_word),
      .cfg(cfg), .lat_eff(lat_eff), .lat_rsvd(lat_rsvd)
   );

   assign sync_md = !cfg.async_md;
   assign cap     = sync_md && !ce_n && !adv_n;

   bas_lat_timer #(.CW(LAT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(cap), .lat(lat_eff), .ready(ready)
   );

   assign valid = active && ready;
   assign last  = (len_q != SZ_CONT) && (beat == last_beat(len_q));
   assign step  = valid && !last && !cap && !ce_n && sync_md;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         beat   <= '0;
         len_q  <= SZ_CONT;
         wrap_q <= 1'b0;
      end else if (!sync_md || ce_n) begin
         active <= 1'b0;
      end else if (cap) begin
         active <= 1'b1;
         beat   <= '0;
         len_q  <= len_class(cfg.len);
         wrap_q <= !cfg.no_wrap;
      end else if (valid) begin
         if (last) active <= 1'b0;
         else      beat   <= beat + BEAT_W'(1);
      end
   end

   bas_addr_gen #(.AW(AW)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(cap), .start(addr_in), .step(step),
      .size_cls(len_q), .wrap_en(wrap_q), .addr_q(addr_q)
   );

   assign word_addr  = sync_md ? addr_q : addr_in;
   assign data_valid = sync_md ? valid  : !ce_n;
   assign wait_pin   = (sync_md && active && !ready) ? cfg.wait_hi : !cfg.wait_hi;

   AST_FIRST_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> (!sync_md || !data_valid)); // R3

   AST_VALID_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_md && data_valid) |-> (wait_pin == !cfg.wait_hi)); // R4

   AST_CE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_md && ce_n) |=> (!sync_md || !data_valid)); // R8

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [15:0]   cfg_word = '0;
   logic          ce_n = 1'b1;
   logic          adv_n = 1'b1;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] word_addr;
   logic          data_valid, wait_pin, lat_rsvd;

   int checks = 0;
   int fails  = 0;
   logic cur_pol = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_seq #(.AW(AW), .DEF_LAT(3)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
      .ce_n(ce_n), .adv_n(adv_n), .addr_in(addr_in), .word_addr(word_addr),
      .data_valid(data_valid), .wait_pin(wait_pin), .lat_rsvd(lat_rsvd)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input logic rm, input logic [3:0] lat,
                                      input logic pol, input logic nowrap, input logic [2:0] len);
      return {rm, lat, pol, 6'b0, nowrap, len};
   endfunction

   task automatic set_cfg(input logic [15:0] w);
      @(negedge clk);
      cfg_word = w; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
      cur_pol = w[10];
   endtask

   // one synchronous burst; win = 0 for linear, else wrap window size
   task automatic burst(input string req, input logic [AW-1:0] start, input int lat,
                        input int win, input int n, input bit end_chk,
                        input bit predriven, input bit restart, input logic [AW-1:0] rb);
      if (!predriven) begin
         ce_n = 1'b0; adv_n = 1'b0; addr_in = start;
      end
      @(negedge clk);
      adv_n = 1'b1;
      for (int i = 0; i < lat; i++) begin
         check({req, " latency valid"}, {31'b0, data_valid}, 32'd0);
         check({req, " latency wait"}, {31'b0, wait_pin}, {31'b0, cur_pol});
         @(negedge clk);
      end
      for (int j = 0; j < n; j++) begin
         logic [AW-1:0] e;
         if (win == 0) e = start + AW'(j);
         else e = (start & ~AW'(win-1)) | ((start + AW'(j)) & AW'(win-1));
         check({req, " beat valid"}, {31'b0, data_valid}, 32'd1);
         check({req, " beat addr"}, 32'(word_addr), 32'(e));
         check({req, " beat wait"}, {31'b0, wait_pin}, {31'b0, !cur_pol});
         if (restart && j == n-1) begin
            adv_n = 1'b0; addr_in = rb;
            return;
         end
         @(negedge clk);
      end
      if (end_chk) begin
         check({req, " end valid"}, {31'b0, data_valid}, 32'd0);
         check({req, " end wait"}, {31'b0, wait_pin}, {31'b0, !cur_pol});
      end
      ce_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      addr_in = 24'h00ABC7;
      #1;
      check("R1 reset wait", {31'b0, wait_pin}, 32'd0);
      check("R1 reset flag", {31'b0, lat_rsvd}, 32'd0);
      check("R1 reset async addr", 32'(word_addr), 32'h00ABC7);
   endtask

   task automatic t_async();
      set_cfg(mk(1'b1, 4'd3, 1'b1, 1'b1, 3'b001));
      ce_n = 1'b0; adv_n = 1'b1;
      for (int k = 0; k < 4; k++) begin
         addr_in = {22'h01234, 2'(k)};
         #1;
         check("R2 page word addr", 32'(word_addr), 32'({22'h01234, 2'(k)}));
         check("R2 page valid", {31'b0, data_valid}, 32'd1);
         check("R2 page wait", {31'b0, wait_pin}, 32'd0);
      end
      adv_n = 1'b0; addr_in = 24'h000055;
      @(negedge clk);
      check("R2 adv ignored", 32'(word_addr), 32'h000055);
      ce_n = 1'b1; adv_n = 1'b1;
      #1;
      check("R2 valid follows ce", {31'b0, data_valid}, 32'd0);
   endtask

   task automatic t_linear();
      set_cfg(mk(1'b0, 4'd3, 1'b1, 1'b1, 3'b001));
      burst("R6 R3 linear4", 24'h00001E, 3, 0, 4, 1, 0, 0, '0);
      set_cfg(mk(1'b0, 4'd5, 1'b1, 1'b1, 3'b011));
      burst("R6 R11 linear16", 24'h000107, 5, 0, 16, 1, 0, 0, '0);
   endtask

   task automatic t_wrap();
      set_cfg(mk(1'b0, 4'd2, 1'b1, 1'b0, 3'b010));
      burst("R7 R11 wrap8", 24'h00002D, 2, 8, 8, 1, 0, 0, '0);
      set_cfg(mk(1'b0, 4'd4, 1'b1, 1'b0, 3'b001));
      burst("R7 wrap4", 24'h000046, 4, 4, 4, 1, 0, 0, '0);
      set_cfg(mk(1'b0, 4'd2, 1'b1, 1'b0, 3'b011));
      burst("R7 wrap16", 24'h00033B, 2, 16, 16, 1, 0, 0, '0);
   endtask

   task automatic t_cont();
      set_cfg(mk(1'b0, 4'd3, 1'b1, 1'b0, 3'b111));
      burst("R8 R11 continuous", 24'h0003FA, 3, 0, 20, 0, 0, 0, '0);
      check("R8 ce abort valid", {31'b0, data_valid}, 32'd0);
      check("R8 ce abort wait", {31'b0, wait_pin}, 32'd0);
      set_cfg(mk(1'b0, 4'd2, 1'b1, 1'b1, 3'b100));
      burst("R11 other code continuous", 24'h00FFFC, 2, 0, 20, 0, 0, 0, '0);
      check("R11 other code abort", {31'b0, data_valid}, 32'd0);
   endtask

   task automatic t_polarity();
      set_cfg(mk(1'b0, 4'd3, 1'b0, 1'b1, 3'b001));
      #1;
      check("R5 idle low-polarity wait", {31'b0, wait_pin}, 32'd1);
      burst("R5 R4 low polarity", 24'h000010, 3, 0, 4, 1, 0, 0, '0);
      set_cfg(mk(1'b0, 4'd3, 1'b1, 1'b1, 3'b001));
      #1;
      check("R5 idle high-polarity wait", {31'b0, wait_pin}, 32'd0);
   endtask

   task automatic t_rsvd();
      set_cfg(mk(1'b0, 4'd0, 1'b1, 1'b1, 3'b001));
      #1;
      check("R9 code0 flag", {31'b0, lat_rsvd}, 32'd1);
      burst("R9 code0 acts as 2", 24'h000200, 2, 0, 4, 1, 0, 0, '0);
      set_cfg(mk(1'b0, 4'd1, 1'b1, 1'b1, 3'b001));
      #1;
      check("R9 code1 flag", {31'b0, lat_rsvd}, 32'd1);
      burst("R9 code1 acts as 2", 24'h000300, 2, 0, 4, 1, 0, 0, '0);
      set_cfg(mk(1'b0, 4'd2, 1'b1, 1'b1, 3'b001));
      #1;
      check("R9 code2 flag", {31'b0, lat_rsvd}, 32'd0);
   endtask

   task automatic t_restart();
      set_cfg(mk(1'b0, 4'd2, 1'b1, 1'b1, 3'b001));
      burst("R10 first burst", 24'h000400, 2, 0, 4, 0, 0, 1, 24'h000777);
      burst("R10 restarted burst", 24'h000777, 2, 0, 4, 1, 1, 0, '0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_async();
      t_linear();
      t_wrap();
      t_cont();
      t_polarity();
      t_rsvd();
      t_restart();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule